// File: doc/BRIEF.md
# NAND Bank Strobe Bridge

This block sits between a simple request/ready CPU bus and a shared 8-bit bus wired to up to four external NAND banks. A small register space holds one bank-control word and a status word. The rest of the address space is split into one window per bank. A byte access to a window becomes one strobed cycle on the flash bus. Two offset bits inside the window decide whether a write is a command-latch cycle, an address-latch cycle or a plain data cycle.

Each bank has two bits in the control word, an enable and a chip-assert. The bank's chip enable output goes low only while both bits are set. An access to a bank whose enable bit is clear completes at once and moves no strobe. Write and read strobes have a fixed width: two clocks low followed by two clocks high. The flash ready/busy line passes through a two-stage synchroniser and can then be read from the status word.

Address map (ADDR_W = 20 with the defaults):
- Bit 19 set selects the register space. In that space, the bits below 17 must equal the register offset.
- Bit 19 clear selects a bank window. Bits 18..17 give the bank number.
- Inside a window, bit 16 (offset 0x10000) selects an address-latch cycle and bit 15 (offset 0x08000) selects a command-latch cycle.

Top module: `nand_bank_bridge`

## Requirements
- R1: After reset, every chip enable is high (inactive), WE# and RE# are high, CLE, ALE and the data-bus drive enable are low, and the control word reads back as zero.
- R2: The control word sits at register offset 0x50 and reads back what was written in its low 2*BANKS bits. Bank n takes bit 2n as its enable and bit 2n+1 as its chip-assert.
- R3: The chip enable of bank n is low exactly when bits 2n and 2n+1 of the control word are both set.
- R4: A window write at offset 0x10000 holds ALE high, and a write at offset 0x08000 holds CLE high, for the whole strobe. A write at offset 0 raises neither. When both offset bits are set, only ALE is raised. CLE and ALE are never high together.
- R5: A window write to an enabled bank drives WE# low for 2 clocks and then high for 2 clocks. It drives the write byte on the bus with the drive enable set for all four clocks. Ready rises in the cycle after the high phase, five clock edges after acceptance.
- R6: A window read from an enabled bank drives RE# low for 2 clocks and then high for 2 clocks, keeps WE#, CLE, ALE and the drive enable inactive, and returns on the data output, with ready, the bus byte sampled on the last clock of the low phase.
- R7: A window access to a bank whose enable bit is clear moves no strobe, returns ready one clock after acceptance, and reads as zero.
- R8: Writing the control word with every chip-assert bit (mask 0xaa) cleared raises every chip enable and leaves the enable bits as written. Writing zero disables and deasserts all banks.
- R9: Status offset 0x54 bit 0 gives the ready/busy input (1 = ready) after two synchroniser clocks. A status read accepted on the first or second clock edge after a change still returns the old level.
- R10: Register offsets other than 0x50 and 0x54 read as zero, and writes to them leave the control word unchanged. Register accesses complete with ready one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle access request, taken only when no strobe is in progress |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address: register space or bank window |
| wdata | input | DATA_W | Write data; the byte lane is bits 7..0 |
| rdata | output | DATA_W | Read data, valid while ready is high |
| ready | output | 1 | One-cycle completion pulse |
| ce_n | output | BANKS | Per-bank chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Flash bus byte driven out |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 8 | Flash bus byte read in |
| rb_n | input | 1 | Flash ready/busy, 0 = busy |

## Verification
One address can carry both the command-latch and the address-latch offset bit, so both latch selections can fall on the same access. The bench provokes this by writing at window offset 0x18000 in every bank. It expects ALE alone on each sampled clock of the strobe, and a property forbids CLE and ALE being high together in any cycle. A change of the ready/busy input can also land in the same cycle as a status read. The bench changes the input and reads status on three back-to-back accepts, and expects the old, old and then new level.

// File: rtl/nbb_pkg.sv
// Shared types for the NAND bank bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package nbb_pkg;

    // Kind of flash bus cycle chosen from the window offset.
    typedef enum logic [1:0] {
        CYC_DATA = 2'd0,
        CYC_CMD  = 2'd1,
        CYC_ADDR = 2'd2
    } cyc_kind_e;

    // Result of decoding one bus address.
    typedef struct packed {
        logic      is_reg;   // register space hit
        logic      reg_ok;   // bits between offset and window top are zero
        cyc_kind_e kind;     // latch selection for window writes
    } dec_t;

    localparam logic [7:0] CTRL_OFF = 8'h50;
    localparam logic [7:0] STAT_OFF = 8'h54;

endpackage

// File: rtl/nbb_decode.sv
// Address decoder: splits the CPU address into register space or a bank
// window, picks the bank and selects the latch kind from the offset bits.
// Assumes: the address-latch bit wins if both latch bits are set.
module nbb_decode
    import nbb_pkg::*;
#(
    parameter int WIN_W  = 17,
    parameter int BANK_W = 2,
    localparam int ADDR_W  = WIN_W + BANK_W + 1,
    localparam int ALE_BIT = WIN_W - 1,
    localparam int CLE_BIT = WIN_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [BANK_W-1:0] bank,
    output logic [7:0]        reg_off
);

    // Pure combinational split of the address fields.
    always_comb begin
        dec.is_reg = addr[ADDR_W-1];
        dec.reg_ok = (addr[WIN_W-1:8] == '0);
        if (addr[ALE_BIT])      dec.kind = CYC_ADDR;
        else if (addr[CLE_BIT]) dec.kind = CYC_CMD;
        else                    dec.kind = CYC_DATA;
        bank    = addr[WIN_W+BANK_W-1:WIN_W];
        reg_off = addr[7:0];
    end

endmodule

// File: rtl/nbb_sync.sv
// Multi-stage synchroniser for the flash ready/busy line.
// Assumes: input is asynchronous and slow compared with clk; resets to ready.
module nbb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/nbb_regs.sv
// Bank control and status registers. Holds per-bank enable/assert bits,
// derives the chip enables and serves register reads.
// Assumes: writes arrive as one-cycle strobes, already qualified.
module nbb_regs
    import nbb_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int DATA_W = 32,
    localparam int CTRL_W = 2 * BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              hit_ok,
    input  logic [7:0]        off,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rb_sync,
    output logic [DATA_W-1:0] rd_val,
    output logic [BANKS-1:0]  en_vec,
    output logic [BANKS-1:0]  ce_n
);

    logic [CTRL_W-1:0] ctrl_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];

    // Control word: updated only by a write to its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ctrl_q <= '0;
        else if (wr_en && hit_ok && off == CTRL_OFF) ctrl_q <= wdata[CTRL_W-1:0];
    end

    // Per-bank enable and chip-enable decode.
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        assign en_vec[g] = ctrl_q[2*g];
        assign ce_n[g]   = ~(ctrl_q[2*g] & ctrl_q[2*g+1]);
    end

    // Register read mux; unmapped offsets read zero.
    always_comb begin
        rd_val = '0;
        if (hit_ok && off == CTRL_OFF)      rd_val[CTRL_W-1:0] = ctrl_q;
        else if (hit_ok && off == STAT_OFF) rd_val[0] = rb_sync;
    end

endmodule

// File: rtl/nbb_strobe.sv
// Strobe sequencer: runs one fixed-width WE# or RE# pulse on the flash
// bus, holding CLE/ALE and write data steady across low and high phases.
// Assumes: start is only raised while idle is high.
module nbb_strobe
    import nbb_pkg::*;
#(
    parameter int PULSE_LO = 2,
    parameter int PULSE_HI = 2,
    localparam int CNT_MAX = (PULSE_LO > PULSE_HI) ? PULSE_LO : PULSE_HI,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      wr,
    input  cyc_kind_e kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] dq_in,
    output logic      idle,
    output logic      done,
    output logic [7:0] rbyte,
    output logic      we_n,
    output logic      re_n,
    output logic      cle,
    output logic      ale,
    output logic [7:0] dq_out,
    output logic      dq_oe
);

    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} st_e;

    st_e              st;
    logic [CNT_W-1:0] cnt;
    logic             is_rd;

    assign idle = (st == ST_IDLE);

    // Phase sequencing and registered strobe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            is_rd  <= 1'b0;
            done   <= 1'b0;
            rbyte  <= '0;
            we_n   <= 1'b1;
            re_n   <= 1'b1;
            cle    <= 1'b0;
            ale    <= 1'b0;
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st    <= ST_LOW;
                        cnt   <= '0;
                        is_rd <= !wr;
                        rbyte <= '0;
                        if (wr) begin
                            we_n   <= 1'b0;
                            dq_oe  <= 1'b1;
                            dq_out <= wbyte;
                            cle    <= (kind == CYC_CMD);
                            ale    <= (kind == CYC_ADDR);
                        end else begin
                            re_n <= 1'b0;
                        end
                    end
                end
                ST_LOW: begin
                    if (cnt == CNT_W'(PULSE_LO - 1)) begin
                        we_n <= 1'b1;
                        re_n <= 1'b1;
                        if (is_rd) rbyte <= dq_in;
                        st  <= ST_HIGH;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt == CNT_W'(PULSE_HI - 1)) begin
                        st    <= ST_IDLE;
                        cnt   <= '0;
                        done  <= 1'b1;
                        cle   <= 1'b0;
                        ale   <= 1'b0;
                        dq_oe <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_bank_bridge.sv
// Top of the NAND bank bridge. Accepts one CPU access at a time. It either
// serves a register in one clock or runs one strobed flash cycle on the
// selected bank window.
// Assumes: req is a one-cycle pulse; the host waits for ready before the
// next request.
module nand_bank_bridge
    import nbb_pkg::*;
#(
    parameter int BANKS    = 4,
    parameter int DATA_W   = 32,
    parameter int WIN_W    = 17,
    parameter int PULSE_LO = 2,
    parameter int PULSE_HI = 2,
    parameter int SYNC_N   = 2,
    localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int ADDR_W  = WIN_W + BANK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic [BANKS-1:0]  ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    input  logic [7:0]        dq_in,
    input  logic              rb_n
);

    dec_t              dec;
    logic [BANK_W-1:0] bank_sel;
    logic [7:0]        reg_off;
    logic [BANKS-1:0]  en_vec;
    logic [DATA_W-1:0] reg_rd;
    logic              rb_sync;
    logic              idle;
    logic              accept;
    logic              live;
    logic              sdone;
    logic [7:0]        rbyte;
    logic              quick_q;
    logic [DATA_W-1:0] rdata_q;

    nbb_decode #(.WIN_W(WIN_W), .BANK_W(BANK_W)) i_decode (
        .addr    (addr),
        .dec     (dec),
        .bank    (bank_sel),
        .reg_off (reg_off)
    );

    nbb_sync #(.STAGES(SYNC_N)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rb_n),
        .dout  (rb_sync)
    );

    nbb_regs #(.BANKS(BANKS), .DATA_W(DATA_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && dec.is_reg && wr),
        .hit_ok  (dec.reg_ok),
        .off     (reg_off),
        .wdata   (wdata),
        .rb_sync (rb_sync),
        .rd_val  (reg_rd),
        .en_vec  (en_vec),
        .ce_n    (ce_n)
    );

    // Accept when no strobe runs; a live target is an enabled bank window.
    assign accept = req && idle;
    assign live   = !dec.is_reg && en_vec[bank_sel];

    nbb_strobe #(.PULSE_LO(PULSE_LO), .PULSE_HI(PULSE_HI)) i_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept && live),
        .wr     (wr),
        .kind   (dec.kind),
        .wbyte  (wdata[7:0]),
        .dq_in  (dq_in),
        .idle   (idle),
        .done   (sdone),
        .rbyte  (rbyte),
        .we_n   (we_n),
        .re_n   (re_n),
        .cle    (cle),
        .ale    (ale),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    // One-clock completion for register and disabled-bank accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quick_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            quick_q <= accept && !live;
            if (accept && !live) rdata_q <= dec.is_reg ? reg_rd : '0;
        end
    end

    assign ready = quick_q | sdone;
    assign rdata = sdone ? {{(DATA_W-8){1'b0}}, rbyte} : rdata_q;

endmodule

// File: rtl/nbb_bridge_chk.sv
// Protocol checker for the NAND bank bridge, bound to every instance.
// Assumes: fixed strobe widths of two clocks low and two high.
module nbb_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic we_n,
    input logic re_n,
    input logic cle,
    input logic ale,
    input logic dq_oe,
    input logic ready
);

    // R4: latch selections are mutually exclusive.
    p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R4: latch lines stay put when the write strobe rises.
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> ($stable(cle) && $stable(ale)));

    // R5: write strobe stays low for a second clock, then is high.
    p_we_low2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !we_n ##1 we_n);

    // R5: write data is driven whenever the write strobe is low.
    p_we_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);

    // R6: read strobe stays low for a second clock, then is high.
    p_re_low2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |=> !re_n ##1 re_n);

    // R6: never drive the bus or write during a read strobe.
    p_re_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> (!dq_oe && we_n));

    // R5: ready is never high while a strobe is low.
    p_ready_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (we_n && re_n));

endmodule

bind nand_bank_bridge nbb_bridge_chk i_bridge_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .we_n  (we_n),
    .re_n  (re_n),
    .cle   (cle),
    .ale   (ale),
    .dq_oe (dq_oe),
    .ready (ready)
);

// File: tb/test_nand_bank_bridge.sv
module test_nand_bank_bridge;

    localparam int ADDR_W = 20;
    localparam logic [19:0] REG_BASE = 20'h80000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [19:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready;
    logic [3:0]  ce_n;
    logic        cle, ale, we_n, re_n, dq_oe;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in = 8'h00;
    logic        rb_n = 1'b1;

    int checks = 0;
    int errors = 0;

    // Per-negedge samples taken during one access (index 1 = first after accept).
    logic s_we [1:8];
    logic s_re [1:8];
    logic s_cle[1:8];
    logic s_ale[1:8];
    logic s_oe [1:8];
    logic [7:0] s_dq[1:8];
    logic [3:0] s_ce[1:8];
    int   lat;
    logic [31:0] rd;

    always #5 clk = ~clk;

    nand_bank_bridge i_nand_bank_bridge (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .ce_n(ce_n),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_in(dq_in), .rb_n(rb_n)
    );

    task automatic check(input string req_tag, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
        end
    endtask

    // Issue one access at the current negedge and wait for ready.
    task automatic access(input logic w, input logic [19:0] a,
                          input logic [31:0] d);
        req = 1'b1; wr = w; addr = a; wdata = d;
        lat = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            req = 1'b0;
            lat = k;
            if (k <= 8) begin
                s_we[k] = we_n; s_re[k] = re_n; s_cle[k] = cle; s_ale[k] = ale;
                s_oe[k] = dq_oe; s_dq[k] = dq_out; s_ce[k] = ce_n;
            end
            if (ready) begin
                rd = rdata;
                break;
            end
        end
    endtask

    function automatic logic [3:0] exp_ce(input logic [7:0] v);
        logic [3:0] r;
        for (int n = 0; n < 4; n++) r[n] = !(v[2*n] && v[2*n+1]);
        return r;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", {28'd0, ce_n}, 32'hF, "ce_n after reset");
        check("R1", {27'd0, we_n, re_n, cle, ale, dq_oe}, 32'h18, "strobes after reset");
        access(1'b0, REG_BASE | 20'h50, 0);
        check("R1", rd, 0, "control word after reset");

        // R2/R3: exhaustive sweep of the control word, R10 latency
        for (int v = 0; v < 256; v++) begin
            access(1'b1, REG_BASE | 20'h50, 32'hFFFFFF00 | v);
            check("R10", lat, 1, "register write latency");
            check("R3", {28'd0, ce_n}, {28'd0, exp_ce(8'(v))}, "chip enables");
            access(1'b0, REG_BASE | 20'h50, 0);
            check("R2", rd, v, "control readback");
        end

        // R8: clear every assert bit with mask 0xaa, keep the enables
        access(1'b1, REG_BASE | 20'h50, 32'hFF);
        access(1'b1, REG_BASE | 20'h50, 32'hFF & ~32'hAA);
        check("R8", {28'd0, ce_n}, 32'hF, "ce_n after assert clear");
        access(1'b0, REG_BASE | 20'h50, 0);
        check("R8", rd, 32'h55, "enables kept after assert clear");
        access(1'b1, REG_BASE | 20'h50, 0);
        access(1'b0, REG_BASE | 20'h50, 0);
        check("R8", rd, 0, "zero write disables all");
        check("R8", {28'd0, ce_n}, 32'hF, "ce_n after zero write");

        // R10: unmapped offsets read zero and do not touch the control word
        access(1'b1, REG_BASE | 20'h50, 32'h3C);
        access(1'b1, REG_BASE | 20'h58, 32'hFF);
        access(1'b1, REG_BASE | 20'h150, 32'hFF);
        access(1'b0, REG_BASE | 20'h50, 0);
        check("R10", rd, 32'h3C, "control after unmapped writes");
        access(1'b0, REG_BASE | 20'h5C, 0);
        check("R10", rd, 0, "unmapped offset read");

        // R7: disabled banks (all enables clear)
        access(1'b1, REG_BASE | 20'h50, 0);
        for (int b = 0; b < 4; b++) begin
            access(1'b1, 20'(b << 17) | 20'h10000, 32'hA5);
            check("R7", lat, 1, "disabled write latency");
            check("R7", {30'd0, s_we[1], s_re[1]}, 32'h3, "no strobe on disabled bank");
            check("R7", {31'd0, s_ale[1]}, 0, "no ALE on disabled bank");
            dq_in = 8'hC3;
            access(1'b0, 20'(b << 17), 0);
            check("R7", rd, 0, "disabled read data");
            check("R7", lat, 1, "disabled read latency");
        end

        // R4/R5: writes on every enabled bank at every offset kind
        access(1'b1, REG_BASE | 20'h50, 32'hFF);
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 4; k++) begin
                logic [19:0] off;
                logic e_ale, e_cle;
                logic [7:0] byt;
                off   = 20'(k) << 15;
                e_ale = off[16];
                e_cle = off[15] && !off[16];
                byt   = 8'(8'h11 * (b * 4 + k + 1));
                access(1'b1, 20'(b << 17) | off, {24'hFFFFFF, byt});
                check("R5", lat, 5, "write latency");
                for (int j = 1; j <= 4; j++) begin
                    check("R5", {31'd0, s_we[j]}, (j > 2) ? 1 : 0, "WE# phase");
                    check("R5", {31'd0, s_oe[j]}, 1, "drive enable");
                    check("R5", {24'd0, s_dq[j]}, {24'd0, byt}, "bus byte");
                    check("R4", {31'd0, s_ale[j]}, {31'd0, e_ale}, "ALE level");
                    check("R4", {31'd0, s_cle[j]}, {31'd0, e_cle}, "CLE level");
                    check("R5", {31'd0, s_re[j]}, 1, "RE# idle during write");
                end
                check("R3", {28'd0, s_ce[1]}, 0, "ce_n during strobe");
                check("R4", {30'd0, cle, ale}, 0, "latches released at ready");
                check("R5", {31'd0, dq_oe}, 0, "drive released at ready");
            end
        end

        // R6: reads on every enabled bank
        for (int b = 0; b < 4; b++) begin
            logic [7:0] pat;
            pat   = 8'(8'h5A ^ (b * 8'h27));
            dq_in = pat;
            access(1'b0, 20'(b << 17), 0);
            check("R6", lat, 5, "read latency");
            check("R6", rd, {24'd0, pat}, "read byte");
            for (int j = 1; j <= 4; j++) begin
                check("R6", {31'd0, s_re[j]}, (j > 2) ? 1 : 0, "RE# phase");
                check("R6", {29'd0, s_we[j], s_oe[j], s_cle[j] | s_ale[j]}, 32'h4, "quiet write side");
            end
        end

        // R9: ready/busy change meets status reads on consecutive accepts
        rb_n = 1'b0;
        access(1'b0, REG_BASE | 20'h54, 0);
        check("R9", rd, 1, "status on first edge after change");
        access(1'b0, REG_BASE | 20'h54, 0);
        check("R9", rd, 1, "status on second edge after change");
        access(1'b0, REG_BASE | 20'h54, 0);
        check("R9", rd, 0, "status after sync");
        rb_n = 1'b1;
        repeat (3) @(negedge clk);
        access(1'b0, REG_BASE | 20'h54, 0);
        check("R9", rd, 1, "status back to ready");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule